// File: doc/BRIEF.md
# Addressed SPI Slave Port

This block is a SPI slave for host access. It works entirely in the system clock domain. The select, serial clock and data-in lines pass through synchronizers, and transitions on the synchronized copies drive all of the framing.

A transaction opens when the select line goes low and closes when it goes high. The host sends bits most significant first, and the port takes them on rising serial-clock edges. The first byte of a transaction holds a 7-bit device address in its upper bits and a direction flag in bit 0.

- **Matching address, write:** every later complete byte goes out on a one-cycle data strobe, with an interrupt pulse in the same cycle.
- **Matching address, read:** the port fetches bytes from a simple byte source and shifts them out on the data-out line.
- **Any other address:** the port stays silent until the select line rises.

The system clock must run at least 8 times faster than the serial clock.

Top module: `spi_addr_slave`

## Requirements
- R1: After reset, and while the select line is high, busy, irq, wr_valid, rd_req and spi_miso_oe are all 0. A falling edge on spi_cs_n starts a transaction, and the first 8 bits after it form the address byte.
- R2: Bits are taken from spi_mosi on rising spi_sck edges, 8 bits per byte, most significant bit first. A transaction may carry any number of bytes.
- R3: The address byte is accepted when its bits [7:1] equal DEV_ADDR (default 7'b1000000). Bit 0 selects the direction: 0 is a write and 1 is a read. The default write address byte is therefore 0x80 and the read address byte is 0x81.
- R4: On an accepted read, rd_req pulses for one cycle after the address byte and again after each complete read byte. The port captures rd_data in the cycle that rd_req is high. Its MSB appears on spi_miso before the next rising spi_sck edge, and later bits change only after falling edges. spi_miso_oe is 1 from acceptance until the Stop.
- R5: When the address does not match, spi_miso_oe, busy, wr_valid, irq and rd_req all stay 0 until the next Stop, whatever bytes follow.
- R6: On an accepted write, each complete data byte produces exactly one wr_valid cycle, and wr_data holds that byte in that cycle.
- R7: irq is high in exactly the cycles in which wr_valid is high.
- R8: busy rises once an address byte is accepted. It falls in the cycle after the synchronized select line is seen high.
- R9: A Stop in the middle of a byte discards the partial byte. The next transaction starts again with an address byte.
- R10: If the 8th rising edge of a write byte arrives in the same system cycle as the Stop, the byte is still delivered on wr_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for spi_miso; 0 means tri-stated |
| wr_data | output | BYTE_W | Received write byte |
| wr_valid | output | 1 | One-cycle strobe for wr_data |
| rd_req | output | 1 | One-cycle fetch request to the byte source |
| rd_data | input | BYTE_W | Byte from the source, valid while rd_req is high |
| busy | output | 1 | Accepted transaction in progress |
| irq | output | 1 | One-cycle pulse per completed write byte |

## Verification
Two things can land in the same system cycle: the Stop (select rising) and the completion of a byte on its 8th rising clock edge. The bench forces this by raising spi_sck and spi_cs_n at the same instant during the last bit of a write byte. Both pass through identical synchronizers, so the two edges reach the controller together. The case is judged at the ports: the byte must appear once on wr_valid with its exact value, and busy must be low afterwards. A partial-byte Stop follows, which must deliver nothing, and a fresh transaction must then frame its bytes correctly.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRITE,
    ST_READ,
    ST_SKIP
  } spi_slv_state_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= RST_VAL;
    else     stage_q[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RST_VAL;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_edge.sv
module spi_edge #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= d;
  end

  generate
    for (genvar g = 0; g < W; g++) begin : g_bit
      assign rise[g] =  d[g] & ~prev_q[g];
      assign fall[g] = ~d[g] &  prev_q[g];
    end
  endgenerate
endmodule

// File: rtl/spi_addr_slave.sv
module spi_addr_slave
  import spi_slv_pkg::*;
#(
  parameter int                BYTE_W      = 8,
  parameter logic [BYTE_W-2:0] DEV_ADDR    = 7'b1000000,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_valid,
  output logic              rd_req,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              busy,
  output logic              irq
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  // synchronized {select, clock, data}
  logic [2:0] sync_vec;
  logic       cs_s, sck_s, mosi_s;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_cs_n, spi_sck, spi_mosi}),
    .q   (sync_vec)
  );

  assign cs_s   = sync_vec[2];
  assign sck_s  = sync_vec[1];
  assign mosi_s = sync_vec[0];

  // edges on {select, clock}
  logic [1:0] rise_v, fall_v;

  spi_edge #(.W(2), .RST_VAL(2'b10)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .d    ({cs_s, sck_s}),
    .rise (rise_v),
    .fall (fall_v)
  );

  logic txn_start, txn_stop, sck_up, sck_dn;
  assign txn_start = fall_v[1];
  assign txn_stop  = rise_v[1];
  assign sck_up    = rise_v[0];
  assign sck_dn    = fall_v[0];

  spi_slv_state_t    state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-2:0] rx_q;
  logic [BYTE_W-1:0] tx_q;
  logic [BYTE_W-1:0] rx_next;
  logic              active, byte_done;

  assign rx_next   = {rx_q, mosi_s};
  assign active    = (state_q != ST_IDLE);
  assign byte_done = active && sck_up && (bit_cnt_q == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
      wr_data     <= '0;
      wr_valid    <= 1'b0;
      irq         <= 1'b0;
      rd_req      <= 1'b0;
      busy        <= 1'b0;
      spi_miso_oe <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      irq      <= 1'b0;
      rd_req   <= 1'b0;

      // serial capture
      if (active && sck_up) begin
        rx_q      <= rx_next[BYTE_W-2:0];
        bit_cnt_q <= (bit_cnt_q == LAST_BIT) ? '0 : bit_cnt_q + 1'b1;
      end

      // byte framing
      if (byte_done) begin
        unique case (state_q)
          ST_ADDR: begin
            if (rx_next[BYTE_W-1:1] == DEV_ADDR) begin
              busy <= 1'b1;
              if (rx_next[0]) begin
                state_q     <= ST_READ;
                spi_miso_oe <= 1'b1;
                rd_req      <= 1'b1;
              end else begin
                state_q <= ST_WRITE;
              end
            end else begin
              state_q <= ST_SKIP;
            end
          end
          ST_WRITE: begin
            wr_data  <= rx_next;
            wr_valid <= 1'b1;
            irq      <= 1'b1;
          end
          ST_READ: rd_req <= 1'b1;
          default: ;
        endcase
      end

      // serial output: load on fetch, shift after falling edges inside a byte
      if (rd_req)
        tx_q <= rd_data;
      else if (sck_dn && state_q == ST_READ && bit_cnt_q != '0)
        tx_q <= {tx_q[BYTE_W-2:0], 1'b0};

      // framing conditions take priority over everything above
      if (txn_start) begin
        state_q     <= ST_ADDR;
        bit_cnt_q   <= '0;
        busy        <= 1'b0;
        spi_miso_oe <= 1'b0;
      end
      if (txn_stop) begin
        state_q     <= ST_IDLE;
        bit_cnt_q   <= '0;
        busy        <= 1'b0;
        spi_miso_oe <= 1'b0;
        rd_req      <= 1'b0;
      end
    end
  end

  assign spi_miso = tx_q[BYTE_W-1];

  // R8: busy falls the cycle after select is seen high
  a_r8_busy_clears: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_s) |=> !busy);
  // R4: the data-out drive only exists inside an accepted transaction
  a_r4_oe_inside_busy: assert property (@(posedge clk) disable iff (rst)
    spi_miso_oe |-> busy);
  // R4: fetch requests are single-cycle pulses
  a_r4_rdreq_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
  // R6: one strobe per byte, never back to back
  a_r6_wr_single: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);
  // R5: an ignored transaction raises no strobes
  a_r5_skip_quiet: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SKIP) |=> (!wr_valid && !rd_req && !busy));
  // R7: interrupt pulse accompanies each write strobe
  a_r7_irq_follows_wr: assert property (@(posedge clk) disable iff (rst)
    irq == wr_valid);
endmodule

// File: tb/test_spi_addr_slave.sv
`timescale 1ns/1ps
module test_spi_addr_slave;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       spi_cs_n = 1'b1;
  logic       spi_sck = 1'b0;
  logic       spi_mosi = 1'b0;
  logic       spi_miso, spi_miso_oe;
  logic [7:0] wr_data;
  logic       wr_valid, rd_req, busy, irq;
  logic [7:0] rd_data;
  logic [7:0] rd_idx = 8'd0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] wr_log [512];
  int wr_n = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] src_byte(input logic [7:0] i);
    return i * 8'd37 + 8'd11;
  endfunction

  assign rd_data = src_byte(rd_idx);
  always @(posedge clk) if (rd_req) rd_idx <= rd_idx + 8'd1;

  spi_addr_slave i_spi_addr_slave (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .wr_data(wr_data), .wr_valid(wr_valid), .rd_req(rd_req),
    .rd_data(rd_data), .busy(busy), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R7 and R6 monitor, away from the active edge
  always @(negedge clk) begin
    if (!rst && (wr_valid || irq)) begin
      chk(wr_valid === irq, "R7", int'(irq), int'(wr_valid));
      if (wr_valid && wr_n < 512) begin
        wr_log[wr_n] = wr_data;
        wr_n++;
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_txn();
    spi_cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic end_txn();
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(3 * HALF);
  endtask

  task automatic send_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_mosi = tx[i];
      wait_clk(HALF);
      rx[i] = spi_miso;
      spi_sck = 1'b1;
      wait_clk(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    send_bits(tx, 8, rx);
  endtask

  initial begin
    #(4 * 195000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    int base_wr;
    logic [7:0] base_rd;

    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    // R1: idle after reset
    chk({busy, irq, wr_valid, rd_req, spi_miso_oe} == 5'b0, "R1",
        int'({busy, irq, wr_valid, rd_req, spi_miso_oe}), 0);

    // R2/R3/R6/R8: write sweep of every byte value in one transaction
    base_wr = wr_n;
    begin_txn();
    chk(busy == 1'b0, "R1", int'(busy), 0);
    xfer(8'h80, rx);
    wait_clk(HALF);
    chk(busy == 1'b1, "R8", int'(busy), 1);
    chk(spi_miso_oe == 1'b0, "R3", int'(spi_miso_oe), 0);
    for (int v = 0; v < 256; v++) xfer(8'(v), rx);
    end_txn();
    chk(busy == 1'b0, "R8", int'(busy), 0);
    chk(wr_n - base_wr == 256, "R2", wr_n - base_wr, 256);
    for (int v = 0; v < 256; v++)
      chk(wr_log[base_wr + v] == 8'(v), "R6", int'(wr_log[base_wr + v]), v);

    // R4: read stream
    base_rd = rd_idx;
    base_wr = wr_n;
    begin_txn();
    xfer(8'h81, rx);
    wait_clk(2);
    chk(spi_miso_oe == 1'b1, "R4", int'(spi_miso_oe), 1);
    chk(busy == 1'b1, "R8", int'(busy), 1);
    for (int i = 0; i < 16; i++) begin
      xfer(8'hC3, rx);
      chk(rx == src_byte(base_rd + 8'(i)), "R4", int'(rx), int'(src_byte(base_rd + 8'(i))));
    end
    end_txn();
    chk(spi_miso_oe == 1'b0, "R4", int'(spi_miso_oe), 0);
    chk(rd_idx - base_rd == 8'd17, "R4", int'(rd_idx - base_rd), 17);
    chk(wr_n == base_wr, "R3", wr_n - base_wr, 0);

    // R5: every other address byte is ignored
    base_rd = rd_idx;
    base_wr = wr_n;
    for (int a = 0; a < 128; a++) begin
      for (int d = 0; d < 2; d++) begin
        if (a != 'h40) begin
          begin_txn();
          xfer({7'(a), 1'(d)}, rx);
          xfer(8'h81, rx);
          chk({busy, spi_miso_oe} == 2'b00, "R5", int'({busy, spi_miso_oe}), 0);
          end_txn();
        end
      end
    end
    chk(wr_n == base_wr, "R5", wr_n - base_wr, 0);
    chk(rd_idx == base_rd, "R5", int'(rd_idx - base_rd), 0);

    // R9: Stop inside a data byte, then a fresh transaction
    base_wr = wr_n;
    begin_txn();
    xfer(8'h80, rx);
    send_bits(8'hFF, 3, rx);
    end_txn();
    chk(wr_n == base_wr, "R9", wr_n - base_wr, 0);
    begin_txn();
    xfer(8'h80, rx);
    xfer(8'h5A, rx);
    end_txn();
    chk(wr_n - base_wr == 1 && wr_log[base_wr] == 8'h5A, "R9",
        int'(wr_log[base_wr]), 'h5A);

    // R9: Stop inside the address byte
    base_wr = wr_n;
    begin_txn();
    send_bits(8'h80, 5, rx);
    end_txn();
    chk(busy == 1'b0, "R9", int'(busy), 0);
    begin_txn();
    xfer(8'h80, rx);
    xfer(8'hC3, rx);
    end_txn();
    chk(wr_n - base_wr == 1 && wr_log[base_wr] == 8'hC3, "R9",
        int'(wr_log[base_wr]), 'hC3);

    // R10: last rising edge and Stop in the same instant
    base_wr = wr_n;
    begin_txn();
    xfer(8'h80, rx);
    send_bits(8'h3D, 7, rx);
    spi_mosi = 1'b1;
    wait_clk(HALF);
    spi_sck  = 1'b1;
    spi_cs_n = 1'b1;
    wait_clk(HALF);
    spi_sck = 1'b0;
    wait_clk(3 * HALF);
    chk(wr_n - base_wr == 1, "R10", wr_n - base_wr, 1);
    chk(wr_log[base_wr] == 8'h3D, "R10", int'(wr_log[base_wr]), 'h3D);
    chk(busy == 1'b0, "R10", int'(busy), 0);
    // framing still sound afterwards
    begin_txn();
    xfer(8'h80, rx);
    xfer(8'h96, rx);
    end_txn();
    chk(wr_n - base_wr == 2 && wr_log[base_wr + 1] == 8'h96, "R10",
        int'(wr_log[base_wr + 1]), 'h96);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule